// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block watches a set of already-synchronized GPIO input levels and turns per-pin conditions into a single interrupt request for a parent interrupt controller. Each pin is set up on its own. It can respond to a level or to an edge. An edge can be a single edge of a chosen direction, or any transition. A level can be active-high or active-low.

All configuration is held in 32-bit words, with one bit per pin. Software reaches these words over a small register bus. A latched edge event stays pending until software pulses that pin's clear bit low and then returns it high.

Software sees two status views. The raw view shows the pending state before masking. The masked view shows it after the per-pin enable is applied. The parent interrupt is the registered OR of every masked pending bit.

The pin count must be a multiple of 32.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is low. The edge-select, both-edge, polarity and enable registers read as zero. The clear register reads as all ones.
- R2: The bus address is `{select[2:0], word}`, and pin p sits at bit p%32 of word p/32. The selects are: 0 edge-select, 1 both-edge, 2 polarity, 3 enable, 4 clear, 5 raw status (read-only), 6 masked status (read-only), 7 unused. Select 7 reads zero. Writes to selects 5 to 7 change nothing.
- R3: A pin whose edge-select bit is 0 is in level mode. Its raw status equals its input when its polarity bit is 1, and the inverted input when its polarity bit is 0. Nothing is latched: the status drops as soon as the level goes inactive.
- R4: A pin with edge-select 1 and both-edge 0 latches a pending event on a rising input when polarity is 1, and on a falling input when polarity is 0. The opposite edge has no effect. The pending event stays set after the input changes back.
- R5: A pin with edge-select 1 and both-edge 1 latches on any transition, whatever its polarity bit holds.
- R6: While a pin's clear bit is 0, its latched event is removed on the next clock edge and no new event can latch. Setting the clear bit back to 1 does not bring back an event.
- R7: A pin's masked status is its raw status ANDed with its enable bit.
- R8: `irq_out` goes high on the clock edge after any masked status bit is set, and low on the clock edge after all of them are clear.
- R9: A transition that reaches the clock edge on which edge-select, both-edge or polarity of the pin's word is written is not latched. Transitions on later edges are latched normally.
- R10: A read is registered. `bus_rdata` holds the selected word from the clock edge on which `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | `{select, word}` address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 64 | Synchronized pin levels |
| irq_out | output | 1 | Merged parent interrupt |

## Verification
The results arrive at different depths:
- A level-mode change reaches `irq_out` one clock edge after the input moves.
- An edge event needs two edges: one to latch and one to merge.
- A clear-bit write takes effect on `irq_out` two edges after the write edge.
- Read data is valid from the edge that samples `bus_rd`.

Inputs are driven on the falling edge. The bench then waits exactly that many falling edges before sampling. Reads go through a queue, and a monitor pops each entry on the falling edge after the read was accepted.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W = 32;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_EDGE = 3'd0,
        SEL_BOTH = 3'd1,
        SEL_POL  = 3'd2,
        SEL_EN   = 3'd3,
        SEL_CLR  = 3'd4,
        SEL_RAW  = 3'd5,
        SEL_MSK  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    // per-pin trigger configuration as seen by a pin cell
    typedef struct packed {
        logic edge_mode;
        logic any_edge;
        logic active_high;
        logic clr_n;
    } pin_cfg_t;

    function automatic int words_for(int pins);
        return (pins + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int idx_bits(int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction

    function automatic logic level_hit(pin_cfg_t c, logic cur);
        return c.active_high ? cur : ~cur;
    endfunction

    function automatic logic edge_hit(pin_cfg_t c, logic cur, logic prev);
        logic r;
        if (c.any_edge)
            r = cur ^ prev;
        else if (c.active_high)
            r = cur & ~prev;
        else
            r = prev & ~cur;
        return r;
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int NWORDS   = 2,
    parameter int IDX_W    = 1,
    parameter int ADDR_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [NUM_PINS-1:0]   raw_st,
    input  logic [NUM_PINS-1:0]   msk_st,
    output logic [WORD_W-1:0]     rdata,
    output pin_cfg_t [NUM_PINS-1:0] cfg,
    output logic [NUM_PINS-1:0]   en_vec,
    output logic [NWORDS-1:0]     cfg_touch
);

    reg_sel_e           sel;
    logic [IDX_W-1:0]   idx;
    logic [NUM_PINS-1:0] edge_q, both_q, pol_q, en_q, clr_q;
    logic [WORD_W-1:0]  rd_next;

    assign sel = reg_sel_e'(addr[ADDR_W-1 -: SEL_W]);
    assign idx = addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            both_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
            clr_q  <= '1;
        end else if (wr_en) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (idx == IDX_W'(w)) begin
                    case (sel)
                        SEL_EDGE: edge_q[w*WORD_W +: WORD_W] <= wdata;
                        SEL_BOTH: both_q[w*WORD_W +: WORD_W] <= wdata;
                        SEL_POL:  pol_q[w*WORD_W +: WORD_W]  <= wdata;
                        SEL_EN:   en_q[w*WORD_W +: WORD_W]   <= wdata;
                        SEL_CLR:  clr_q[w*WORD_W +: WORD_W]  <= wdata;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rd_next = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (idx == IDX_W'(w)) begin
                case (sel)
                    SEL_EDGE: rd_next = edge_q[w*WORD_W +: WORD_W];
                    SEL_BOTH: rd_next = both_q[w*WORD_W +: WORD_W];
                    SEL_POL:  rd_next = pol_q[w*WORD_W +: WORD_W];
                    SEL_EN:   rd_next = en_q[w*WORD_W +: WORD_W];
                    SEL_CLR:  rd_next = clr_q[w*WORD_W +: WORD_W];
                    SEL_RAW:  rd_next = raw_st[w*WORD_W +: WORD_W];
                    SEL_MSK:  rd_next = msk_st[w*WORD_W +: WORD_W];
                    default:  rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end

    // a write to any trigger field of a word blinds that word for one edge
    always_comb begin
        for (int w = 0; w < NWORDS; w++)
            cfg_touch[w] = wr_en && (idx == IDX_W'(w)) &&
                           (sel == SEL_EDGE || sel == SEL_BOTH || sel == SEL_POL);
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++)
            cfg[p] = '{edge_mode: edge_q[p], any_edge: both_q[p],
                       active_high: pol_q[p], clr_n: clr_q[p]};
    end

    assign en_vec = en_q;

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     cur,
    input  logic     touch,
    output logic     raw,
    output logic     latched
);

    logic prev_q;
    logic latch_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= cur;
    end

    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= 1'b0;
        else if (!cfg.clr_n || !cfg.edge_mode)
            latch_q <= 1'b0;
        else if (!touch && edge_hit(cfg, cur, prev_q))
            latch_q <= 1'b1;
    end

    assign raw     = cfg.edge_mode ? latch_q : level_hit(cfg, cur);
    assign latched = latch_q;

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] raw,
    input  logic [NUM_PINS-1:0] en,
    output logic [NUM_PINS-1:0] masked,
    output logic                irq
);

    assign masked = raw & en;

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= |masked;
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int NWORDS  = words_for(NUM_PINS),
    localparam int IDX_W   = idx_bits(NWORDS),
    localparam int ADDR_W  = SEL_W + IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                irq_out
);

    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0] en_vec;
    logic [NUM_PINS-1:0] raw_vec;
    logic [NUM_PINS-1:0] msk_vec;
    logic [NUM_PINS-1:0] latch_vec;
    logic [NUM_PINS-1:0] edge_vec;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NWORDS-1:0]   cfg_touch;

    gpio_irq_regs #(
        .NUM_PINS(NUM_PINS), .NWORDS(NWORDS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata),
        .raw_st(raw_vec), .msk_st(msk_vec), .rdata(bus_rdata),
        .cfg(cfg), .en_vec(en_vec), .cfg_touch(cfg_touch)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk(clk), .rst(rst), .cfg(cfg[p]), .cur(pin_in[p]),
            .touch(cfg_touch[p / WORD_W]),
            .raw(raw_vec[p]), .latched(latch_vec[p])
        );
        assign edge_vec[p] = cfg[p].edge_mode;
        assign clr_vec[p]  = cfg[p].clr_n;
    end

    gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_merge (
        .clk(clk), .rst(rst), .raw(raw_vec), .en(en_vec),
        .masked(msk_vec), .irq(irq_out)
    );

endmodule

// File: rtl/gpio_irq_checks.sv
module gpio_irq_checks #(
    parameter int NUM_PINS = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                irq_out,
    input logic [NUM_PINS-1:0] msk_vec,
    input logic [NUM_PINS-1:0] en_vec,
    input logic [NUM_PINS-1:0] clr_vec,
    input logic [NUM_PINS-1:0] edge_vec,
    input logic [NUM_PINS-1:0] latch_vec
);

    assert_reset_R1: assert property (@(posedge clk) rst |=> !irq_out);

    assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
        (|msk_vec) |=> irq_out);

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !(|msk_vec) |=> !irq_out);

    assert_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (msk_vec & ~en_vec) == '0);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (latch_vec & $past(~clr_vec)) == '0);

    assert_edge_only_R4: assert property (@(posedge clk) disable iff (rst)
        (latch_vec & ~$past(latch_vec) & ~$past(edge_vec)) == '0);

endmodule

bind gpio_irq_ctrl gpio_irq_checks #(.NUM_PINS(NUM_PINS)) u_checks (
    .clk(clk), .rst(rst), .irq_out(irq_out), .msk_vec(msk_vec),
    .en_vec(en_vec), .clr_vec(clr_vec), .edge_vec(edge_vec),
    .latch_vec(latch_vec)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    import gpio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pins = '0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pins), .irq_out(irq_out)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input reg_sel_e sel, input logic w, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = {sel, w}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_write_pin(input reg_sel_e sel, input logic w, input logic [31:0] d,
                                 input int pin, input logic v);
        bus_wr = 1'b1; bus_addr = {sel, w}; bus_wdata = d; pins[pin] = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: issue a read and hand the expectation to the monitor
    task automatic expect_read(input reg_sel_e sel, input logic w, input logic [31:0] e,
                               input string tag);
        bus_rd = 1'b1; bus_addr = {sel, w};
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        checks++;
        if (irq_out !== e) begin
            fails++;
            $display("FAIL %s: irq_out=%0b expected %0b", tag, irq_out, e);
        end
    endtask

    task automatic clear_pin40();
        bus_write(SEL_CLR, 1'b1, 32'hFFFF_FEFF);
        bus_write(SEL_CLR, 1'b1, 32'hFFFF_FFFF);
        tick(2);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: compare read data on the falling edge after the read was taken
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata=%08h expected %08h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        check_irq(1'b0, "R1 irq after reset");
        expect_read(SEL_EN,   1'b0, 32'h0, "R1 enable word0 reset");
        expect_read(SEL_EDGE, 1'b0, 32'h0, "R1 edge-select word0 reset");
        expect_read(SEL_CLR,  1'b1, 32'hFFFF_FFFF, "R1 clear word1 reset");
        expect_read(SEL_RAW,  1'b0, 32'hFFFF_FFFF, "R3 low-active raw with pins low");
        expect_read(SEL_MSK,  1'b0, 32'h0, "R7 masked with enables off");
        expect_read(SEL_NONE, 1'b0, 32'h0, "R2 unused select reads zero");
        bus_write(SEL_RAW, 1'b0, 32'h0);
        expect_read(SEL_RAW,  1'b0, 32'hFFFF_FFFF, "R2 write to raw ignored");
        expect_read(SEL_POL,  1'b0, 32'h0, "R2 polarity untouched by raw write");

        // level mode, pin 3 active-high
        bus_write(SEL_POL, 1'b0, 32'h8);
        bus_write(SEL_EN,  1'b0, 32'h8);
        tick(1);
        check_irq(1'b0, "R3 inactive high-level pin");
        pins[3] = 1'b1; tick(1);
        check_irq(1'b1, "R8 level reaches irq one edge later");
        expect_read(SEL_MSK, 1'b0, 32'h8, "R7 masked shows pin3");
        expect_read(SEL_RAW, 1'b0, 32'hFFFF_FFFF, "R3 raw with pin3 high");
        pins[3] = 1'b0; tick(1);
        check_irq(1'b0, "R3 level not latched");

        // masking
        pins[3] = 1'b1;
        bus_write(SEL_EN, 1'b0, 32'h0);
        tick(1);
        check_irq(1'b0, "R7 disabled pin masked");
        expect_read(SEL_MSK, 1'b0, 32'h0, "R7 masked status cleared");
        bus_write(SEL_EN, 1'b0, 32'h8);
        tick(1);
        check_irq(1'b1, "R7 re-enabled pin");
        pins[3] = 1'b0; tick(1);
        check_irq(1'b0, "R3 level low again");

        // rising edge on pin 40 (word1 bit8)
        bus_write(SEL_EDGE, 1'b1, 32'h100);
        bus_write(SEL_POL,  1'b1, 32'h100);
        bus_write(SEL_EN,   1'b1, 32'h100);
        tick(1);
        check_irq(1'b0, "R4 no event before edge");
        expect_read(SEL_RAW, 1'b1, 32'hFFFF_FEFF, "R4 raw word1 before edge");
        pins[40] = 1'b1; tick(1);
        check_irq(1'b0, "R8 edge not yet merged");
        tick(1);
        check_irq(1'b1, "R4 rising edge latched");
        pins[40] = 1'b0; tick(2);
        check_irq(1'b1, "R4 latch held after input falls");
        expect_read(SEL_MSK, 1'b1, 32'h100, "R4 masked word1 pending");

        // clear handshake
        bus_write(SEL_CLR, 1'b1, 32'hFFFF_FEFF);
        tick(2);
        check_irq(1'b0, "R6 clear low removes event");
        pins[40] = 1'b1; tick(2);
        check_irq(1'b0, "R6 edge blocked while clear low");
        expect_read(SEL_RAW, 1'b1, 32'hFFFF_FEFF, "R6 raw stays clear");
        bus_write(SEL_CLR, 1'b1, 32'hFFFF_FFFF);
        tick(2);
        check_irq(1'b0, "R6 no event on clear release");

        // falling edge
        bus_write(SEL_POL, 1'b1, 32'h0);
        pins[40] = 1'b0; tick(2);
        check_irq(1'b1, "R4 falling edge latched");
        clear_pin40();
        check_irq(1'b0, "R6 cleared after pulse");
        pins[40] = 1'b1; tick(2);
        check_irq(1'b0, "R4 rising ignored in falling mode");

        // any transition
        bus_write(SEL_BOTH, 1'b1, 32'h100);
        pins[40] = 1'b0; tick(2);
        check_irq(1'b1, "R5 fall in both-edge mode");
        clear_pin40();
        pins[40] = 1'b1; tick(2);
        check_irq(1'b1, "R5 rise with polarity 0");
        clear_pin40();

        // transition on a configuration write edge
        bus_write_pin(SEL_POL, 1'b1, 32'h0, 40, 1'b0);
        tick(2);
        check_irq(1'b0, "R9 transition on config write ignored");
        pins[40] = 1'b1; tick(2);
        check_irq(1'b1, "R9 detection resumes");
        clear_pin40();

        // merge across words
        pins[3] = 1'b1; pins[40] = 1'b0; tick(2);
        check_irq(1'b1, "R8 two sources");
        clear_pin40();
        check_irq(1'b1, "R8 level source keeps irq");
        expect_read(SEL_MSK, 1'b0, 32'h8, "R8 masked word0");
        expect_read(SEL_MSK, 1'b1, 32'h0, "R10 masked word1 read");
        pins[3] = 1'b0; tick(1);
        check_irq(1'b0, "R8 all sources clear");

        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule